// File: doc/BRIEF.md
# RTC Control/Status Registers and Interrupt Unit

This block holds the two byte-wide control and status registers of a real-time clock. They sit on a simple synchronous register port with an address, write data, a write strobe and a combinational read-data path. The first register (address 00h) holds the run/stop control for the seconds prescaler and two stored test-configuration bits. The second register (address 01h) holds the alarm and timer flags, their interrupt enables, and the bit that selects level or pulse mode for timer interrupts. Single-cycle alarm-match and timer-expiry inputs set the flags. An active-low interrupt line combines the enabled alarm flag with the timer term.

When the stop bit is set, the prescaler divider is forced to zero asynchronously and the seconds tick stops. The raw oscillator clock keeps running on its own output. In pulse mode, a small state machine stretches each timer event into a fixed-width interrupt pulse. It has two states: `PI_IDLE` and `PI_ACTIVE`. Its transitions are: *fire* (PI_IDLE to PI_ACTIVE on an event), *retrigger* (an event in PI_ACTIVE reloads the width counter), *count* (PI_ACTIVE stays while the counter is non-zero) and *expire* (PI_ACTIVE to PI_IDLE when the counter reaches zero with no new event).

Top module: `rtc_ctrl_status`

## Requirements
- R1: After reset, address 00h reads 08h, address 01h reads 00h, the interrupt output is high (inactive), the test-configuration output is 0 and the power-on-override output is 1.
- R2: Register 00h keeps writable bits only at bit 7 (external-clock test select, shown on `ext_test_o`), bit 5 (stop) and bit 3 (power-on override, shown on `por_ovr_o`). Writes to its other bits are ignored, and those bits read 0. For example, writing FFh reads back A8h.
- R3: Register 01h has these fields: bit 4 selects timer pulse mode, bit 3 is the alarm flag, bit 2 is the timer flag, bit 1 enables the alarm interrupt and bit 0 enables the timer interrupt. Bits 7 to 5 are ignored on write and read 0.
- R4: Writing 0 to a flag bit of 01h clears that flag. Writing 1 leaves it unchanged, so software can never set a flag.
- R5: While stop is 1, `sec_tick_o` stays low and `clkout_o` keeps toggling with the oscillator. After stop returns to 0, the first tick appears 2^DIV_BITS − 1 cycles after the clock edge that cleared stop.
- R6: While the alarm flag and the alarm enable are both 1, `irq_n_o` is held low until the flag is cleared.
- R7: In level mode (bit 4 = 0), `irq_n_o` is low while the timer flag and the timer enable are both 1. Clearing the enable releases it.
- R8: In pulse mode, each timer event drives `irq_n_o` low for exactly PULSE_W cycles, starting in the cycle after the event, if the timer enable is set. An event during a pulse restarts the full width. The timer flag is still set but does not hold the line.
- R9: An alarm event sets the alarm flag and a timer event sets the timer flag. An event wins over a clearing write in the same cycle.
- R10: Reads from any address other than 00h and 01h return 00h, and writes there change nothing.
- R11: While running, `sec_tick_o` is high for one cycle out of every 2^DIV_BITS cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| alarm_hit_i | input | 1 | Single-cycle alarm-match event |
| timer_done_i | input | 1 | Single-cycle timer-expiry event |
| irq_n_o | output | 1 | Active-low interrupt |
| sec_tick_o | output | 1 | One-cycle prescaler tick |
| clkout_o | output | 1 | Raw oscillator clock, never gated by stop |
| ext_test_o | output | 1 | Stored external-clock test select |
| por_ovr_o | output | 1 | Stored power-on-override enable |

## Verification
The bench builds the block with DIV_BITS = 3 and PULSE_W = 4. The narrow divider makes the resume point after stop, and two whole tick periods, fit within a couple of dozen cycles, so each tick can be checked at its exact cycle. The short pulse width makes it possible to follow single pulses, a retrigger in mid-pulse and the release cycle one by one. The default values only stretch those same windows.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
    localparam int unsigned REG_W       = 8;
    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_IRQ    = 1;

    localparam int unsigned TEST1_BIT   = 7;
    localparam int unsigned STOP_BIT    = 5;
    localparam int unsigned TESTC_BIT   = 3;

    localparam int unsigned PULSE_BIT   = 4;
    localparam int unsigned AF_BIT      = 3;
    localparam int unsigned TF_BIT      = 2;
    localparam int unsigned AIE_BIT     = 1;
    localparam int unsigned TIE_BIT     = 0;

    localparam logic [REG_W-1:0] CTRL_MASK  = 8'hA8;
    localparam logic [REG_W-1:0] CTRL_RST   = 8'h08;
    localparam logic [REG_W-1:0] CFG_MASK   = 8'h13;

    typedef enum logic [0:0] {
        PI_IDLE   = 1'b0,
        PI_ACTIVE = 1'b1
    } pulse_state_e;
endpackage

// File: rtl/rtcc_ctrl_regs.sv
module rtcc_ctrl_regs
    import rtcc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              we,
    input  logic              alarm_hit,
    input  logic              timer_done,
    output logic [REG_W-1:0]  rdata,
    output logic              test1,
    output logic              stop,
    output logic              testc,
    output logic              pulse_mode,
    output logic              af,
    output logic              tf,
    output logic              aie,
    output logic              tie
);
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] cfg_q;
    logic             af_q;
    logic             tf_q;
    logic             hit_ctrl;
    logic             hit_irq;
    logic             wr_ctrl;
    logic             wr_irq;

    assign hit_ctrl = (addr == ADDR_W'(ADDR_CTRL));
    assign hit_irq  = (addr == ADDR_W'(ADDR_IRQ));
    assign wr_ctrl  = we && hit_ctrl;
    assign wr_irq   = we && hit_irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            cfg_q  <= '0;
            af_q   <= 1'b0;
            tf_q   <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
            if (wr_irq)  cfg_q  <= wdata & CFG_MASK;
            af_q <= alarm_hit  || (af_q && !(wr_irq && !wdata[AF_BIT]));
            tf_q <= timer_done || (tf_q && !(wr_irq && !wdata[TF_BIT]));
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata = ctrl_q;
        end else if (hit_irq) begin
            rdata         = cfg_q;
            rdata[AF_BIT] = af_q;
            rdata[TF_BIT] = tf_q;
        end
    end

    assign test1      = ctrl_q[TEST1_BIT];
    assign stop       = ctrl_q[STOP_BIT];
    assign testc      = ctrl_q[TESTC_BIT];
    assign pulse_mode = cfg_q[PULSE_BIT];
    assign aie        = cfg_q[AIE_BIT];
    assign tie        = cfg_q[TIE_BIT];
    assign af         = af_q;
    assign tf         = tf_q;

    // R4: software alone can never raise a flag
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!af_q && !alarm_hit) |=> !af_q);
    // R4: a zero written to the alarm flag clears it when no event competes
    p_clear_af_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq && !wdata[AF_BIT] && !alarm_hit) |=> !af_q);
    // R9: events win over clearing writes
    p_alarm_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> af_q);
    p_timer_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timer_done |=> tf_q);
endmodule

// File: rtl/rtcc_pulse_fsm.sv
module rtcc_pulse_fsm
    import rtcc_pkg::*;
#(
    parameter int unsigned PULSE_W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_o
);
    localparam int unsigned CNT_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_W - 1);

    pulse_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PI_IDLE: begin
                if (trig) begin            // fire
                    state_d = PI_ACTIVE;
                    cnt_d   = RELOAD;
                end
            end
            PI_ACTIVE: begin
                if (trig) begin            // retrigger
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin  // expire
                    state_d = PI_IDLE;
                end else begin             // count
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PI_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PI_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pulse_o = (state_q == PI_ACTIVE);
    end

    // R8: an event always opens a pulse on the next cycle
    p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse_o);
    // R8: the pulse closes once the width is used up
    p_pulse_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PI_ACTIVE && cnt_q == '0 && !trig) |=> !pulse_o);
endmodule

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
    parameter int unsigned DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick_o
);
    logic [DIV_BITS-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n or posedge hold) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (&cnt_q) && !hold;

    // R5: the chain sits at zero whenever stop is asserted
    p_stop_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (cnt_q == '0));
    // R11: a tick lasts exactly one cycle
    p_tick_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/rtc_ctrl_status.sv
module rtc_ctrl_status
    import rtcc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DIV_BITS = 15,
    parameter int unsigned PULSE_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              alarm_hit_i,
    input  logic              timer_done_i,
    output logic              irq_n_o,
    output logic              sec_tick_o,
    output logic              clkout_o,
    output logic              ext_test_o,
    output logic              por_ovr_o
);
    logic stop, pulse_mode, af, tf, aie, tie;
    logic timer_pulse, timer_term, irq;

    rtcc_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .we         (bus_we),
        .alarm_hit  (alarm_hit_i),
        .timer_done (timer_done_i),
        .rdata      (bus_rdata),
        .test1      (ext_test_o),
        .stop       (stop),
        .testc      (por_ovr_o),
        .pulse_mode (pulse_mode),
        .af         (af),
        .tf         (tf),
        .aie        (aie),
        .tie        (tie)
    );

    rtcc_pulse_fsm #(.PULSE_W(PULSE_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (timer_done_i && pulse_mode),
        .pulse_o (timer_pulse)
    );

    rtcc_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (stop),
        .tick_o (sec_tick_o)
    );

    assign timer_term = pulse_mode ? timer_pulse : tf;
    assign irq        = (af && aie) || (tie && timer_term);
    assign irq_n_o    = !irq;
    assign clkout_o   = clk;

    // R6: an enabled alarm keeps the line low until a register write intervenes
    p_alarm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && af && aie && !(bus_we && bus_addr == ADDR_W'(ADDR_IRQ)))
        |=> !irq_n_o);
endmodule

// File: tb/test_rtc_ctrl_status.sv
module test_rtc_ctrl_status;
    localparam int DIV_BITS = 3;
    localparam int PULSE_W  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic       alarm_hit = 1'b0;
    logic       timer_done = 1'b0;
    logic       irq_n, tick, clkout, ext_test, por_ovr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ckcnt = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          sel;   // 0 rdata 1 irq_n 2 tick 3 ext_test 4 por_ovr 5 clkout edges
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t q[$];
    item_t keep[$];

    rtc_ctrl_status #(.ADDR_W(8), .DIV_BITS(DIV_BITS), .PULSE_W(PULSE_W)) i_rtc_ctrl_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_we       (we),
        .bus_rdata    (rdata),
        .alarm_hit_i  (alarm_hit),
        .timer_done_i (timer_done),
        .irq_n_o      (irq_n),
        .sec_tick_o   (tick),
        .clkout_o     (clkout),
        .ext_test_o   (ext_test),
        .por_ovr_o    (por_ovr)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clkout) ckcnt <= ckcnt + 1;

    function automatic logic [31:0] observe(input int sel);
        case (sel)
            0: return {24'd0, rdata};
            1: return {31'd0, irq_n};
            2: return {31'd0, tick};
            3: return {31'd0, ext_test};
            4: return {31'd0, por_ovr};
            default: return ckcnt;
        endcase
    endfunction

    // monitor: pops items that are due and compares them
    initial forever begin
        @(negedge clk);
        #2;
        keep = {};
        foreach (q[i]) begin
            if (q[i].due <= cyc) begin
                logic [31:0] act;
                act = observe(q[i].sel);
                checks++;
                if (act !== q[i].exp) begin
                    errors++;
                    $display("FAIL %s sel%0d cyc %0d act %0h exp %0h",
                             q[i].req, q[i].sel, cyc, act, q[i].exp);
                end
            end else begin
                keep.push_back(q[i]);
            end
        end
        q = keep;
    end

    task automatic push(input int due, input int sel, input logic [31:0] e, input string r);
        item_t it;
        it.due = due; it.sel = sel; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic expect_now(input int sel, input logic [31:0] e, input string r);
        push(cyc, sel, e, r);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string r);
        @(negedge clk);
        addr = a;
        push(cyc, 0, {24'd0, e}, r);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic timer_event();
        @(negedge clk);
        timer_done = 1'b1;
        @(negedge clk);
        timer_done = 1'b0;
    endtask

    task automatic alarm_event();
        @(negedge clk);
        alarm_hit = 1'b1;
        @(negedge clk);
        alarm_hit = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired at cyc %0d", cyc);
            summary();
        end
    end

    initial begin
        int c;
        int ck0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(8'h00, 8'h08, "R1");
        expect_rd(8'h01, 8'h00, "R1");
        expect_now(1, 1, "R1");
        expect_now(3, 0, "R1");
        expect_now(4, 1, "R1");

        // R2 unused bits ignored; R5 stop holds the tick, clkout still runs
        bus_write(8'h00, 8'hFF);
        c = cyc;
        ck0 = ckcnt;
        for (int k = 0; k < 10; k++) push(c + k, 2, 0, "R5");
        push(c + 10, 5, ck0 + 10, "R5");
        expect_rd(8'h00, 8'hA8, "R2");
        expect_now(3, 1, "R2");
        expect_now(4, 1, "R2");
        idle(10);

        // R5 resume point, R11 tick period
        bus_write(8'h00, 8'h00);
        c = cyc;
        for (int k = 0; k < 16; k++)
            push(c + k, 2, (k == 7 || k == 15) ? 1 : 0, (k < 8) ? "R5" : "R11");
        expect_rd(8'h00, 8'h00, "R2");
        expect_now(4, 0, "R2");
        idle(16);

        // R3 / R4: reserved bits dropped, flags not settable by software
        bus_write(8'h01, 8'hFF);
        expect_rd(8'h01, 8'h13, "R3");
        expect_now(1, 1, "R4");

        // R6 / R9: alarm holds the line
        alarm_event();
        expect_now(1, 0, "R6");
        expect_rd(8'h01, 8'h1B, "R9");
        idle(5);
        expect_now(1, 0, "R6");
        bus_write(8'h01, 8'h1B);
        expect_rd(8'h01, 8'h1B, "R4");
        expect_now(1, 0, "R6");
        bus_write(8'h01, 8'h13);
        expect_rd(8'h01, 8'h13, "R4");
        expect_now(1, 1, "R6");

        // R8: pulse mode single pulse
        timer_event();
        c = cyc;
        for (int k = 0; k <= PULSE_W; k++) push(c + k, 1, (k < PULSE_W) ? 0 : 1, "R8");
        idle(6);
        expect_rd(8'h01, 8'h17, "R8");
        expect_now(1, 1, "R8");

        // R8: retrigger restarts the width
        timer_event();
        c = cyc;
        push(c, 1, 0, "R8");
        push(c + 1, 1, 0, "R8");
        timer_event();
        c = cyc;
        for (int k = 0; k <= PULSE_W; k++) push(c + k, 1, (k < PULSE_W) ? 0 : 1, "R8");
        idle(6);
        bus_write(8'h01, 8'h13);
        expect_rd(8'h01, 8'h13, "R4");

        // R7: level mode
        bus_write(8'h01, 8'h01);
        timer_event();
        expect_now(1, 0, "R7");
        idle(5);
        expect_now(1, 0, "R7");
        expect_rd(8'h01, 8'h05, "R7");
        bus_write(8'h01, 8'h04);
        expect_now(1, 1, "R7");
        expect_rd(8'h01, 8'h04, "R7");
        bus_write(8'h01, 8'h00);
        expect_rd(8'h01, 8'h00, "R4");

        // R9: event beats clearing write in the same cycle
        @(negedge clk);
        addr = 8'h01; wdata = 8'h00; we = 1'b1; alarm_hit = 1'b1; timer_done = 1'b1;
        @(negedge clk);
        we = 1'b0; alarm_hit = 1'b0; timer_done = 1'b0;
        expect_rd(8'h01, 8'h0C, "R9");
        expect_now(1, 1, "R9");

        // R10: other addresses
        bus_write(8'h02, 8'hFF);
        expect_rd(8'h02, 8'h00, "R10");
        expect_rd(8'h07, 8'h00, "R10");
        expect_rd(8'h01, 8'h0C, "R10");
        expect_rd(8'h00, 8'h00, "R10");

        idle(4);
        if (q.size() != 0) begin
            errors += q.size();
            $display("FAIL scoreboard %0d items never compared act %0d exp 0", q.size(), q.size());
        end
        if (!done) begin
            done = 1'b1;
            summary();
        end
    end
endmodule